// File: doc/BRIEF.md
# Iterative Shift Multiply/Divide Datapath

This block is the arithmetic engine of a small 16-bit processor core. An opcode and two word operands arrive together with a one-cycle start pulse. Addition, subtraction and a single-bit test complete at the first clock edge. An unsigned multiply or an unsigned divide takes one pass per operand bit. Each pass moves a 32-bit value held in a pair of word registers, an upper half and a lower half, by one place. The same 16-bit adder serves every operation. During division, and for plain subtraction, it receives the bit-inverted second operand. A small constants source supplies the carry-in of one that turns this into a two's-complement subtract.

A 6-bit repetition counter sequences the multi-cycle operations. While it runs, `busy` is high and any new start pulse is dropped. On completion `done` pulses for one cycle. At that point `result` carries the 32-bit product, or the remainder in the upper word and the quotient in the lower word. The zero, carry and error flags are updated at the same time. A zero divisor does not start the loop. It is reported at once and leaves the result untouched.

Top module: `shift_muldiv_dp`

## Requirements
- R1: After a synchronous reset, `result` is 0, `zero`, `carry` and `div_err` are 0, and `done` and `busy` are low.
- R2: Opcode 2 (add) and the unused codes 5, 6 and 7 give `result[15:0]` = opa + opb mod 2^16, with `result[31:16]` = 0 and `carry` = the carry out of bit 15. `done` is high in the cycle after the edge that samples `start`.
- R3: Opcode 3 (subtract) gives `result[15:0]` = opa − opb mod 2^16, with `result[31:16]` = 0. `carry` is 1 exactly when opa < opb. `done` follows with the same timing as in R2.
- R4: Opcode 0 (multiply) gives `result` = opa × opb as a 32-bit unsigned value. `carry` is 1 when `result[31:16]` is nonzero. `busy` is high for exactly 16 cycles, and `done` rises at the 16th rising edge after the edge that samples `start`.
- R5: Opcode 1 (divide) with opb ≠ 0 gives `result[15:0]` = opa / opb and `result[31:16]` = opa mod opb, both unsigned, with `carry` = 0. It has the same latency and `busy` window as R4.
- R6: Opcode 1 with opb = 0 sets `div_err`, clears `zero` and `carry`, and keeps `result` unchanged. `done` is high in the next cycle and `busy` never rises. Any other completion clears `div_err`.
- R7: Opcode 4 (bit test) gives `result` = opa AND a one-hot mask with bit `bit_sel` set (`bit_sel` selects a bit from 0 to 7). `zero` is 1 when opa[bit_sel] is 0, and `carry` = 0. `done` follows with the same timing as in R2.
- R8: On every completion except a divide error, `zero` is 1 exactly when the full 32-bit `result` is 0.
- R9: `done` is high for exactly one cycle per accepted operation and is never high while `busy` is high.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its own result and timing, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 3 | Opcode: 0 mul, 1 div, 2 add, 3 sub, 4 bit test, 5–7 add |
| opa | input | 16 | First operand, also the dividend or multiplicand |
| opb | input | 16 | Second operand, also the divisor or multiplier |
| bit_sel | input | 3 | Bit index for the bit test |
| result | output | 32 | Upper word and lower word of the shift pair |
| zero | output | 1 | Zero flag |
| carry | output | 1 | Carry, borrow or high-word-nonzero flag |
| div_err | output | 1 | Divide-by-zero flag |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A multiply or divide is iterating |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the middle of a 16-pass loop. The pair registers then hold a half-shifted value, and a wrongly accepted request would corrupt it without any immediate sign. The stimulus launches a multiply, waits a few cycles and pulses start with an add. A cycle-by-cycle model then requires that the original product still appears on time, with no second `done`. A divide by zero issued right after a completed multiply shows whether the result is preserved. Operand extremes are also driven: all ones times all ones, a dividend smaller than its divisor, and a divisor of one.

// File: rtl/shmd_pkg.sv
package shmd_pkg;

    localparam int WORD  = 16;
    localparam int CNT_W = 6;
    localparam int SEL_W = 3;

    typedef enum logic [2:0] {
        OP_MUL  = 3'd0,
        OP_DIV  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_BTST = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } state_e;

    typedef enum logic [1:0] {
        PR_HOLD,
        PR_LOAD,
        PR_MUL,
        PR_DIV
    } pair_mode_e;

    typedef struct packed {
        logic err;
        logic carry;
        logic zero;
    } flags_t;

    // constants source: selector 0 -> 0, 1 -> 1, 2 -> 2
    function automatic logic [1:0] const_value(input logic [1:0] sel);
        case (sel)
            2'd1:    return 2'd1;
            2'd2:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    // map raw opcode to a legal operation; spare codes act as add
    function automatic op_e decode_op(input logic [2:0] raw);
        return (raw > 3'd4) ? OP_ADD : op_e'(raw);
    endfunction

endpackage

// File: rtl/md_alu.sv
module md_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_b,
    input  logic         cin,
    output logic [W:0]   sum
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = inv_b ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/md_pair.sv
module md_pair #(
    parameter int W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  shmd_pkg::pair_mode_e    mode,
    input  logic [W-1:0]            ld_hi,
    input  logic [W-1:0]            ld_lo,
    input  logic [W:0]              alu_sum,
    input  logic                    take,
    output logic [W-1:0]            hi,
    output logic [W-1:0]            lo,
    output logic [W-1:0]            nxt_hi,
    output logic [W-1:0]            nxt_lo
);
    import shmd_pkg::*;

    always_comb begin
        nxt_hi = hi;
        nxt_lo = lo;
        case (mode)
            PR_LOAD: begin
                nxt_hi = ld_hi;
                nxt_lo = ld_lo;
            end
            PR_MUL: begin
                // right shift of {carry, hi, lo} after optional add
                if (take) begin
                    nxt_hi = alu_sum[W:1];
                    nxt_lo = {alu_sum[0], lo[W-1:1]};
                end else begin
                    nxt_hi = {1'b0, hi[W-1:1]};
                    nxt_lo = {hi[0], lo[W-1:1]};
                end
            end
            PR_DIV: begin
                // left shift of {hi, lo}, quotient bit enters at the bottom
                nxt_hi = take ? alu_sum[W-1:0] : {hi[W-2:0], lo[W-1]};
                nxt_lo = {lo[W-2:0], take};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi <= '0;
            lo <= '0;
        end else begin
            hi <= nxt_hi;
            lo <= nxt_lo;
        end
    end
endmodule

// File: rtl/md_loopctr.sv
module md_loopctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] ld_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= ld_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/shift_muldiv_dp.sv
module shift_muldiv_dp #(
    parameter int W     = shmd_pkg::WORD,
    parameter int CW    = shmd_pkg::CNT_W,
    parameter int SEL_W = shmd_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [SEL_W-1:0] bit_sel,
    output logic [2*W-1:0]   result,
    output logic             zero,
    output logic             carry,
    output logic             div_err,
    output logic             done,
    output logic             busy
);
    import shmd_pkg::*;

    localparam logic [CW-1:0] ITER = CW'(W);

    state_e       st;
    op_e          dop;
    flags_t       flg;
    logic         done_q;
    logic [W-1:0] sop;          // second-operand register
    logic [1:0]   kreg;         // constants source output
    logic         accept, long_go, div_zero;

    logic [W-1:0] alu_a, alu_b;
    logic         alu_inv, alu_cin;
    logic [W:0]   alu_sum;

    pair_mode_e   pmode;
    logic [W-1:0] ld_hi, ld_lo, hi, lo, nxt_hi, nxt_lo;
    logic         take, last;
    logic [W-1:0] mask;

    assign dop      = decode_op(op);
    assign accept   = start && (st == ST_IDLE);
    assign div_zero = (dop == OP_DIV) && (opb == '0);
    assign long_go  = accept && ((dop == OP_MUL) || (dop == OP_DIV && !div_zero));
    assign mask     = W'(1) << bit_sel;

    // operand routing into the shared adder
    always_comb begin
        kreg = const_value(2'd0);
        case (st)
            ST_MUL: begin
                alu_a   = hi;
                alu_b   = sop;
                alu_inv = 1'b0;
            end
            ST_DIV: begin
                alu_a   = {hi[W-2:0], lo[W-1]};
                alu_b   = sop;
                alu_inv = 1'b1;
                kreg    = const_value(2'd1);
            end
            default: begin
                alu_a   = opa;
                alu_b   = opb;
                alu_inv = (dop == OP_SUB);
                if (dop == OP_SUB) kreg = const_value(2'd1);
            end
        endcase
        alu_cin = kreg[0];
    end

    md_alu #(.W(W)) u_alu (
        .a(alu_a), .b(alu_b), .inv_b(alu_inv), .cin(alu_cin), .sum(alu_sum)
    );

    // pair control
    always_comb begin
        pmode = PR_HOLD;
        ld_hi = '0;
        ld_lo = '0;
        take  = 1'b0;
        case (st)
            ST_MUL: begin
                pmode = PR_MUL;
                take  = lo[0];
            end
            ST_DIV: begin
                pmode = PR_DIV;
                take  = hi[W-1] | alu_sum[W];
            end
            default: begin
                if (accept) begin
                    case (dop)
                        OP_MUL:  begin pmode = PR_LOAD; ld_lo = opa; end
                        OP_DIV:  if (!div_zero) begin pmode = PR_LOAD; ld_lo = opa; end
                        OP_BTST: begin pmode = PR_LOAD; ld_lo = opa & mask; end
                        default: begin pmode = PR_LOAD; ld_lo = alu_sum[W-1:0]; end
                    endcase
                end
            end
        endcase
    end

    md_pair #(.W(W)) u_pair (
        .clk(clk), .rst(rst), .mode(pmode), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .alu_sum(alu_sum), .take(take), .hi(hi), .lo(lo),
        .nxt_hi(nxt_hi), .nxt_lo(nxt_lo)
    );

    md_loopctr #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(long_go), .dec(st != ST_IDLE),
        .ld_val(ITER), .last(last)
    );

    // sequencing and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sop    <= '0;
            flg    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        case (dop)
                            OP_MUL: begin
                                sop <= opb;
                                st  <= ST_MUL;
                            end
                            OP_DIV: begin
                                if (div_zero) begin
                                    flg    <= '{err: 1'b1, carry: 1'b0, zero: 1'b0};
                                    done_q <= 1'b1;
                                end else begin
                                    sop <= opb;
                                    st  <= ST_DIV;
                                end
                            end
                            OP_SUB: begin
                                flg    <= '{err: 1'b0, carry: ~alu_sum[W],
                                            zero: (alu_sum[W-1:0] == '0)};
                                done_q <= 1'b1;
                            end
                            OP_BTST: begin
                                flg    <= '{err: 1'b0, carry: 1'b0, zero: ~opa[bit_sel]};
                                done_q <= 1'b1;
                            end
                            default: begin
                                flg    <= '{err: 1'b0, carry: alu_sum[W],
                                            zero: (alu_sum[W-1:0] == '0)};
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                end
                default: begin
                    if (last) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                        flg    <= '{err: 1'b0,
                                    carry: (st == ST_MUL) && (nxt_hi != '0),
                                    zero: ({nxt_hi, nxt_lo} == '0)};
                    end
                end
            endcase
        end
    end

    assign result  = {hi, lo};
    assign zero    = flg.zero;
    assign carry   = flg.carry;
    assign div_err = flg.err;
    assign done    = done_q;
    assign busy    = (st != ST_IDLE);
endmodule

// File: rtl/shmd_chk.sv
module shmd_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [2:0]     op,
    input logic [W-1:0]   opb,
    input logic [2*W-1:0] result,
    input logic           zero,
    input logic           div_err,
    input logic           done,
    input logic           busy
);
    localparam int RW = $clog2(W) + 2;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);
    // R10
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == 3'd1 && opb == '0) |=> (done && div_err && $stable(result)));
    // R2
    single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op >= 3'd2) |=> done);
    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !div_err) |-> (zero == (result == '0)));
    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RW'(W)));
    // R4
    loop_length_chk: assert property (@(posedge clk) disable iff (rst)
        (done && run_len != '0) |-> (run_len == RW'(W)));
endmodule

bind shift_muldiv_dp shmd_chk #(.W(W)) u_shmd_chk (
    .clk(clk), .rst(rst), .start(start), .op(op), .opb(opb),
    .result(result), .zero(zero), .div_err(div_err), .done(done), .busy(busy)
);

// File: tb/shift_muldiv_dp_bench.sv
module shift_muldiv_dp_bench;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    op = '0;
    logic [W-1:0]  opa = '0, opb = '0;
    logic [2:0]    bit_sel = '0;
    logic [31:0]   result;
    logic          zero, carry, div_err, done, busy;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    shift_muldiv_dp u_shift_muldiv_dp (
        .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
        .bit_sel(bit_sel), .result(result), .zero(zero), .carry(carry),
        .div_err(div_err), .done(done), .busy(busy)
    );

    // behavioural reference model
    bit         m_busy, m_done, m_zero, m_carry, m_err;
    int         m_left;
    bit [31:0]  m_res, m_pend;
    bit         p_zero, p_carry;
    string      m_tag = "R1";

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_res = 0; m_zero = 0; m_carry = 0; m_err = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_res = m_pend;
                    m_zero = p_zero; m_carry = p_carry; m_err = 0;
                end
            end else if (start) begin
                bit [16:0] s;
                case (op)
                    3'd0: begin
                        m_tag = "R4"; m_busy = 1; m_left = W;
                        m_pend = 32'(opa) * 32'(opb);
                        p_carry = (m_pend[31:16] != 0); p_zero = (m_pend == 0);
                    end
                    3'd1: begin
                        if (opb == 0) begin
                            m_tag = "R6"; m_done = 1; m_err = 1; m_zero = 0; m_carry = 0;
                        end else begin
                            m_tag = "R5"; m_busy = 1; m_left = W;
                            m_pend = {opa % opb, opa / opb};
                            p_carry = 0; p_zero = (m_pend == 0);
                        end
                    end
                    3'd3: begin
                        m_tag = "R3"; m_done = 1; m_err = 0;
                        m_res = {16'h0, 16'(opa - opb)};
                        m_carry = (opa < opb); m_zero = (m_res == 0);
                    end
                    3'd4: begin
                        m_tag = "R7"; m_done = 1; m_err = 0;
                        m_res = {16'h0, opa & (16'h1 << bit_sel)};
                        m_carry = 0; m_zero = !opa[bit_sel];
                    end
                    default: begin
                        m_tag = "R2"; m_done = 1; m_err = 0;
                        s = 17'(opa) + 17'(opb);
                        m_res = {16'h0, s[15:0]};
                        m_carry = s[16]; m_zero = (m_res == 0);
                    end
                endcase
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(done == m_done, {m_tag, " R9/R10 done"}, done, m_done);
            chk(busy == m_busy, {m_tag, " R9/R10 busy"}, busy, m_busy);
            if (m_done) begin
                chk(result == m_res, {m_tag, " result"}, result, m_res);
                chk(zero == m_zero, {m_tag, " R8 zero"}, zero, m_zero);
                chk(carry == m_carry, {m_tag, " carry"}, carry, m_carry);
                chk(div_err == m_err, {m_tag, " div_err"}, div_err, m_err);
            end
        end
    end

    task automatic issue(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [2:0] bs);
        @(negedge clk);
        op = o; opa = a; opb = b; bit_sel = bs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] bs);
        issue(o, a, b, bs);
        repeat (W + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(result == 0 && !zero && !carry && !div_err, "R1 reset outputs",
            {result, zero, carry, div_err}, 0);
        chk(!done && !busy, "R1 reset handshake", {done, busy}, 0);

        run(3'd2, 16'h1234, 16'h4321, 0);     // R2 add
        run(3'd2, 16'hFFFF, 16'h0001, 0);     // R2 carry out, zero result
        run(3'd6, 16'h0005, 16'h0007, 0);     // R2 spare code acts as add
        run(3'd3, 16'h0009, 16'h0004, 0);     // R3 subtract
        run(3'd3, 16'h0004, 16'h0009, 0);     // R3 borrow
        run(3'd3, 16'h7777, 16'h7777, 0);     // R3/R8 zero
        run(3'd0, 16'h0003, 16'h0005, 0);     // R4 small multiply
        run(3'd0, 16'hFFFF, 16'hFFFF, 0);     // R4 extreme multiply
        run(3'd0, 16'h1234, 16'h0000, 0);     // R4/R8 zero product
        run(3'd1, 16'd100, 16'd7, 0);         // R5 divide
        run(3'd1, 16'hFFFF, 16'h0001, 0);     // R5 divisor one
        run(3'd1, 16'd5, 16'd9, 0);           // R5 dividend below divisor
        run(3'd1, 16'hFFFF, 16'hFFFF, 0);     // R5 equal operands
        run(3'd0, 16'h00FF, 16'h0101, 0);     // set a known result
        run(3'd1, 16'h1234, 16'h0000, 0);     // R6 divide by zero keeps result
        run(3'd2, 16'h0001, 16'h0001, 0);     // R6 err cleared by next op
        run(3'd4, 16'h0081, 16'h0000, 3'd7);  // R7 bit 7 set
        run(3'd4, 16'h0081, 16'h0000, 3'd1);  // R7 bit 1 clear
        run(3'd4, 16'hFFFE, 16'h0000, 3'd0);  // R7 bit 0 clear

        // R10: start during a multiply must be ignored
        issue(3'd0, 16'd300, 16'd200, 0);
        repeat (4) @(negedge clk);
        issue(3'd2, 16'h0001, 16'h0001, 0);
        repeat (W + 2) @(negedge clk);
        chk(result == 32'd60000, "R10 product survives ignored start", result, 60000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule